// File: doc/BRIEF.md
# Multi-Channel Up-Counting Timer with Selectable Clearing

This block holds a parameterised number of 16-bit up-counters. Each one advances by one on every cycle in which the shared count-enable tick is high and the channel's run bit is set. A three-bit clear-select field picks the mode for each channel. In free-running mode the counter wraps through zero and raises a sticky overflow flag. In periodic mode the counter returns to zero when it equals the channel's compare value, which gives a repeating period of compare + 1 ticks.

Software reaches the block through a single-cycle write port and a combinational read port. Address bits [1:0] select a register inside a channel. The bits above them select the channel. Code 0 is the control field (clear-select in bits [2:0]), code 1 is the counter, code 2 is the compare value and code 3 is the status register. In the status register, bit 0 is the overflow flag and bit 1 is the match flag. The shared run register sits at channel index NCH with register code 0, and bit i of it runs channel i. Unmapped reads return zero.

Top module: `multi_tmr`

## Requirements
- R1: A running channel adds one to its 16-bit counter on each clock edge where `tick` is high, and holds the count when `tick` is low.
- R2: After reset every control field is 000, every counter is 0x0000, every compare value is 0xFFFF, every status register is 0 and the run register is 0.
- R3: A channel counts only while its bit in the run register (address NCH*4) is 1, and each channel counts independently of the others.
- R4: With clear-select 000, the counter wraps from 0xFFFF to 0x0000 on a tick, sets status bit 0 (overflow) and keeps counting from zero.
- R5: With clear-select 001, a tick taken while the counter equals the compare value sets status bit 1 (match), loads 0x0000 into the counter, and counting resumes from zero.
- R6: Clear-select codes 010 through 111 act like 000, and the raw code reads back unchanged.
- R7: In free-running mode, a tick taken while the counter equals the compare value sets status bit 1 and does not clear the counter.
- R8: Writing 0 to a status bit clears it. Writing 1 has no effect.
- R9: When a flag's set event and a software clear of that flag occur in the same cycle, the flag ends up set.
- R10: A write to the counter takes effect only while the channel's run bit is 0. It is ignored while the channel runs.
- R11: A match is detected on the counter value before the increment. In periodic mode the counter therefore shows the compare value until the next tick, and the period is compare + 1 ticks.
- R12: In periodic mode with a compare value of 0xFFFF, the clear from 0xFFFF to 0x0000 sets only the match flag and not the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Shared count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address {channel, register code} |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address {channel, register code} |
| rd_data | output | CNT_W | Combinational read data |

## Verification
The hardest case to reach from the ports is a flag whose set event and software clear arrive on the same edge. To get there, the bench stops ticks with a periodic counter resting exactly on its compare value, confirms the flag is clear, and then raises `tick` and writes zero to the status register in one cycle. A related case is the counter write made while a channel runs: the bench issues it with `tick` low, so any change in the count read back can only come from the ignored write. The case where the overflow and match conditions coincide at 0xFFFF is reached by preloading the counter near the top in both modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // clear-source codes held in each channel's control field
    typedef enum logic [2:0] {
        CLR_NONE  = 3'b000,
        CLR_MATCH = 3'b001
    } clr_sel_e;

    // register code in the low two address bits
    typedef enum logic [1:0] {
        REG_CTL = 2'd0,
        REG_CNT = 2'd1,
        REG_CMP = 2'd2,
        REG_STS = 2'd3
    } reg_sel_e;

    localparam int STS_OVF_BIT = 0;
    localparam int STS_MAT_BIT = 1;
    localparam int CSEL_W      = 3;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [NCH-1:0][CSEL_W-1:0]      csel_i,
    input  logic [NCH-1:0][CNT_W-1:0]       cnt_i,
    input  logic [NCH-1:0][CNT_W-1:0]       cmp_i,
    input  logic [NCH-1:0]                  ovf_i,
    input  logic [NCH-1:0]                  mat_i,
    output logic [NCH-1:0]                  run_o,
    output logic [NCH-1:0]                  wr_ctl_o,
    output logic [NCH-1:0]                  wr_cnt_o,
    output logic [NCH-1:0]                  wr_cmp_o,
    output logic [NCH-1:0]                  wr_sts_o,
    output logic [CNT_W-1:0]                rd_data
);

    localparam int CH_W = ADDR_W - 2;

    typedef struct packed {
        logic [NCH-1:0] run;
    } regs_state_t;

    regs_state_t cur_q, nxt_d;

    logic [CH_W-1:0] wr_chan, rd_chan;
    reg_sel_e        wr_sel, rd_sel;
    logic            run_wr;

    assign wr_chan = wr_addr[ADDR_W-1:2];
    assign wr_sel  = reg_sel_e'(wr_addr[1:0]);
    assign rd_chan = rd_addr[ADDR_W-1:2];
    assign rd_sel  = reg_sel_e'(rd_addr[1:0]);
    assign run_wr  = wr_en && (wr_chan == CH_W'(NCH)) && (wr_sel == REG_CTL);

    // per-channel write strobes
    for (genvar g = 0; g < NCH; g++) begin : g_dec
        logic hit;
        assign hit         = wr_en && (wr_chan == CH_W'(g));
        assign wr_ctl_o[g] = hit && (wr_sel == REG_CTL);
        assign wr_cnt_o[g] = hit && (wr_sel == REG_CNT);
        assign wr_cmp_o[g] = hit && (wr_sel == REG_CMP);
        assign wr_sts_o[g] = hit && (wr_sel == REG_STS);
    end

    always_comb begin
        nxt_d = cur_q;
        if (run_wr) begin
            nxt_d.run = wr_data[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run_o = cur_q.run;

    // read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_chan == CH_W'(NCH)) begin
            if (rd_sel == REG_CTL) begin
                rd_data[NCH-1:0] = cur_q.run;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (rd_chan == CH_W'(i)) begin
                    case (rd_sel)
                        REG_CTL: rd_data[CSEL_W-1:0] = csel_i[i];
                        REG_CNT: rd_data = cnt_i[i];
                        REG_CMP: rd_data = cmp_i[i];
                        default: begin
                            rd_data[STS_OVF_BIT] = ovf_i[i];
                            rd_data[STS_MAT_BIT] = mat_i[i];
                        end
                    endcase
                end
            end
        end
    end

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_wr |=> $stable(run_o));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                tick_i,
    input  logic                wr_ctl_i,
    input  logic                wr_cnt_i,
    input  logic                wr_cmp_i,
    input  logic                wr_sts_i,
    input  logic [CNT_W-1:0]    wr_data_i,
    output logic [CSEL_W-1:0]   csel_o,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [CNT_W-1:0]    cmp_o,
    output logic                ovf_o,
    output logic                mat_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CSEL_W-1:0] csel;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic              ovf;
        logic              mat;
    } chan_state_t;

    chan_state_t cur_q, nxt_d;

    logic adv, clr_mode, hit, wrap_clr, ovf_ev, mat_ev, ovf_clr, mat_clr;

    always_comb begin
        adv      = run_i && tick_i;
        clr_mode = (cur_q.csel == CLR_MATCH);
        hit      = (cur_q.cnt == cur_q.cmp);
        wrap_clr = clr_mode && hit;
        ovf_ev   = adv && !wrap_clr && (cur_q.cnt == CNT_TOP);
        mat_ev   = adv && hit;
        ovf_clr  = wr_sts_i && !wr_data_i[STS_OVF_BIT];
        mat_clr  = wr_sts_i && !wr_data_i[STS_MAT_BIT];

        nxt_d = cur_q;
        if (wr_ctl_i) begin
            nxt_d.csel = wr_data_i[CSEL_W-1:0];
        end
        if (wr_cmp_i) begin
            nxt_d.cmp = wr_data_i;
        end
        if (adv) begin
            nxt_d.cnt = wrap_clr ? '0 : cur_q.cnt + 1'b1;
        end else if (wr_cnt_i && !run_i) begin
            nxt_d.cnt = wr_data_i;
        end
        nxt_d.ovf = (cur_q.ovf && !ovf_clr) || ovf_ev;
        nxt_d.mat = (cur_q.mat && !mat_clr) || mat_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.csel <= CLR_NONE;
            cur_q.cnt  <= '0;
            cur_q.cmp  <= CNT_TOP;
            cur_q.ovf  <= 1'b0;
            cur_q.mat  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign csel_o = cur_q.csel;
    assign cnt_o  = cur_q.cnt;
    assign cmp_o  = cur_q.cmp;
    assign ovf_o  = cur_q.ovf;
    assign mat_o  = cur_q.mat;

    // R10
    cnt_run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_o));

    // R3
    cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_cnt_i) |=> $stable(cnt_o));

    // R4
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && csel_o != CLR_MATCH && cnt_o == CNT_TOP)
        |=> (ovf_o && cnt_o == '0));

    // R5
    per_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && csel_o == CLR_MATCH && cnt_o == cmp_o)
        |=> (cnt_o == '0 && mat_o));

    // R12
    per_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && run_i && tick_i && csel_o == CLR_MATCH && cnt_o == cmp_o)
        |=> !ovf_o);

    // R8
    mat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mat_o && !(wr_sts_i && !wr_data_i[STS_MAT_BIT])) |=> mat_o);

    // R9
    mat_set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && cnt_o == cmp_o) |=> mat_o);

endmodule

// File: rtl/multi_tmr.sv
module multi_tmr
    import tmr_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int CNT_W = 16,
    localparam int ADDR_W = $clog2(NCH + 1) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);

    logic [NCH-1:0][CSEL_W-1:0] csel_w;
    logic [NCH-1:0][CNT_W-1:0]  cnt_w;
    logic [NCH-1:0][CNT_W-1:0]  cmp_w;
    logic [NCH-1:0]             ovf_w, mat_w, run_w;
    logic [NCH-1:0]             wr_ctl_w, wr_cnt_w, wr_cmp_w, wr_sts_w;

    tmr_regs #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .csel_i   (csel_w),
        .cnt_i    (cnt_w),
        .cmp_i    (cmp_w),
        .ovf_i    (ovf_w),
        .mat_i    (mat_w),
        .run_o    (run_w),
        .wr_ctl_o (wr_ctl_w),
        .wr_cnt_o (wr_cnt_w),
        .wr_cmp_o (wr_cmp_w),
        .wr_sts_o (wr_sts_w),
        .rd_data  (rd_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run_w[g]),
            .tick_i    (tick),
            .wr_ctl_i  (wr_ctl_w[g]),
            .wr_cnt_i  (wr_cnt_w[g]),
            .wr_cmp_i  (wr_cmp_w[g]),
            .wr_sts_i  (wr_sts_w[g]),
            .wr_data_i (wr_data),
            .csel_o    (csel_w[g]),
            .cnt_o     (cnt_w[g]),
            .cmp_o     (cmp_w[g]),
            .ovf_o     (ovf_w[g]),
            .mat_o     (mat_w[g])
        );
    end

endmodule

// File: tb/sim_multi_tmr.sv
`timescale 1ns/1ps
module sim_multi_tmr;

    localparam int NCH    = 3;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = $clog2(NCH + 1) + 2;
    localparam int RUN_A  = NCH * 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [CNT_W-1:0]  rd_data;

    multi_tmr #(.NCH(NCH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [CNT_W-1:0] exp;
        string            tag;
    } item_t;

    item_t sb_q[$];
    logic  smp_req = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // monitor: compare the read port against the queued expectation
    always @(negedge clk) begin
        if (smp_req && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (rd_data !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp);
            end
        end
    end

    function automatic logic [ADDR_W-1:0] ra(int ch, int sel);
        return ADDR_W'(ch * 4 + sel);
    endfunction

    task automatic wr(int a, logic [CNT_W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(int a, logic [CNT_W-1:0] e, string tag);
        item_t it;
        @(posedge clk); #1;
        rd_addr = ADDR_W'(a);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        smp_req = 1'b1;
        @(posedge clk); #1;
        smp_req = 1'b0;
    endtask

    task automatic ticks(int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state
        expect_rd(ra(0, 0), 16'h0000, "R2 ctl");
        expect_rd(ra(0, 1), 16'h0000, "R2 cnt");
        expect_rd(ra(1, 2), 16'hFFFF, "R2 cmp");
        expect_rd(ra(2, 3), 16'h0000, "R2 sts");
        expect_rd(RUN_A,    16'h0000, "R2 run");

        // R3 stopped channel ignores ticks
        ticks(5);
        expect_rd(ra(0, 1), 16'h0000, "R3 stopped");

        // R10 write accepted while stopped; R4 wrap with overflow
        wr(ra(0, 1), 16'hFFFD);
        expect_rd(ra(0, 1), 16'hFFFD, "R10 stopped write");
        wr(RUN_A, 16'h0001);
        ticks(5);
        expect_rd(ra(0, 1), 16'h0002, "R4 wrap count");
        expect_rd(ra(0, 3), 16'h0003, "R4 ovf and R7 match at top");

        // R8 write-0 clears, write-1 keeps
        wr(ra(0, 3), 16'h0002);
        expect_rd(ra(0, 3), 16'h0002, "R8 clear ovf only");
        wr(ra(0, 3), 16'h0000);
        expect_rd(ra(0, 3), 16'h0000, "R8 clear all");

        // R10 write ignored while running
        wr(ra(0, 1), 16'h1234);
        expect_rd(ra(0, 1), 16'h0002, "R10 running write");

        // R5 / R11 periodic mode, compare 4
        wr(RUN_A, 16'h0000);
        wr(ra(0, 1), 16'h0000);
        wr(ra(0, 0), 16'h0001);
        wr(ra(0, 2), 16'h0004);
        wr(RUN_A, 16'h0001);
        ticks(4);
        expect_rd(ra(0, 1), 16'h0004, "R11 holds compare value");
        expect_rd(ra(0, 3), 16'h0000, "R11 no early match");
        ticks(1);
        expect_rd(ra(0, 1), 16'h0000, "R5 cleared");
        expect_rd(ra(0, 3), 16'h0002, "R5 match flag");
        ticks(3);
        expect_rd(ra(0, 1), 16'h0003, "R5 resume");
        expect_rd(ra(0, 1), 16'h0003, "R1 hold without tick");

        // R9 set beats clear in the same cycle
        wr(ra(0, 3), 16'h0000);
        ticks(1);
        expect_rd(ra(0, 3), 16'h0000, "R9 precondition");
        @(posedge clk); #1;
        tick = 1'b1; wr_en = 1'b1; wr_addr = ra(0, 3); wr_data = 16'h0000;
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0;
        expect_rd(ra(0, 3), 16'h0002, "R9 set wins");
        expect_rd(ra(0, 1), 16'h0000, "R9 counter cleared");

        // R7 free-running match, no clear; R3 independence
        wr(ra(1, 2), 16'h0003);
        wr(RUN_A, 16'h0002);
        ticks(6);
        expect_rd(ra(1, 1), 16'h0006, "R7 no clear");
        expect_rd(ra(1, 3), 16'h0002, "R7 match flag");
        expect_rd(ra(0, 1), 16'h0000, "R3 other channel idle");

        // R6 reserved code behaves as free-running; R1 count
        wr(ra(2, 0), 16'h0005);
        wr(ra(2, 2), 16'h0002);
        wr(RUN_A, 16'h0004);
        ticks(5);
        expect_rd(ra(2, 1), 16'h0005, "R6 no clear on reserved code");
        expect_rd(ra(2, 3), 16'h0002, "R6 match flag");
        expect_rd(ra(2, 0), 16'h0005, "R6 code readback");

        // R12 periodic clear at top sets no overflow
        wr(RUN_A, 16'h0000);
        wr(ra(1, 0), 16'h0001);
        wr(ra(1, 2), 16'hFFFF);
        wr(ra(1, 1), 16'hFFFE);
        wr(ra(1, 3), 16'h0000);
        wr(RUN_A, 16'h0002);
        ticks(2);
        expect_rd(ra(1, 1), 16'h0000, "R12 cleared at top");
        expect_rd(ra(1, 3), 16'h0002, "R12 match only");
        wr(ra(1, 3), 16'h0003);
        expect_rd(ra(1, 3), 16'h0002, "R8 write one no effect");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule